// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block sits behind a small register bus and gives a host two ways into a larger address space through a single pointer. A 32-bit pointer register holds a target. A 4-byte data window then redirects every access it receives. When the pointer's top bit is set, the access goes to a local byte-addressed memory. When that bit is clear, the access is sent back into the block's own register decoder.

In both cases the target address is the pointer plus the byte offset inside the window. Accesses are 1, 2 or 4 bytes wide. Sub-word accesses select or replace bytes of a 32-bit word at the byte offset, and memory is little-endian.

Besides the window, the block decodes:
- a few constant status words;
- a 256-byte read-only mirror area;
- a small bank of read/write test registers.

Every other address is inert.

Top module: `idxwin_top`

## Requirements
- R1: Every request is acknowledged exactly one cycle later with `ack` high for one cycle. `rdata` carries the read result on that cycle and is 0 when acknowledging a write.
- R2: The pointer register at address 0x000 is a full 32-bit read/write register.
- R3: The size code selects the access width: 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. Code 3 changes no state and reads 0.
- R4: A register read returns the selected bytes starting at byte offset `addr[1:0]`, right-aligned, with the unused upper bytes 0. A register write replaces only those bytes, taking them from the low bytes of `wdata`. Bytes that would fall past bit 31 are dropped.
- R5: Addresses 0x004 to 0x007 form the data window, with target = pointer + (addr - 0x004). With pointer bit 31 set, the access goes to memory byte address pointer[30:0] + offset. Byte i of the data maps to memory byte address+i.
- R6: A memory access is made only if address + width does not exceed MEM_BYTES. Otherwise the read returns 0 and the write changes nothing.
- R7: With pointer bit 31 clear, a window access acts as a register access issued at the 32-bit target. The target's low two bits are the byte offset.
- R8: A forwarded access whose target lies in the data window, or at or above 2^ADDR_W, is treated as unmapped.
- R9: Status words read as constants and ignore writes:
  - 0x010 returns MEM_BYTES;
  - 0x014 returns 5;
  - 0x018 returns 64;
  - 0x01C returns 64.
- R10: Addresses 0xF00 to 0xFFF are read-only. The word at 0xF00 reads MIRROR_ID, the other words read 0, and writes are ignored.
- R11: TREG_N test registers start at 0x040, one 32-bit read/write word each, and reset to 0.
- R12: Any other address reads 0 and ignores writes.
- R13: After reset, `ack` and `rdata` are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata | input | 32 | Write data, right-aligned |
| ack | output | 1 | Acknowledge, one cycle after `req` |
| rdata | output | 32 | Read data, right-aligned, valid with `ack` |

## Verification
The window is driven with the pointer's top bit set and clear.
- Set: memory reads and writes at every window offset show that the offset is added and that lanes are little-endian.
- Clear: the same window offsets must reach the test bank, the status words and the pointer itself.

Pointer values that place a 4-byte access exactly at the end of memory, or one and two bytes past it, separate a correct bound from an off-by-one. Forwarded targets that land back on the window, or above the register space, must behave as unmapped. Sub-word writes at offset 3 with a 2-byte width show whether the byte past bit 31 is dropped instead of wrapping.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

    // Byte addresses of the decoded registers
    localparam int PTR_A    = 'h000;
    localparam int WIN_A    = 'h004;
    localparam int MSZ_A    = 'h010;
    localparam int MCS_A    = 'h014;
    localparam int ENG_A    = 'h018;
    localparam int GUI_A    = 'h01C;
    localparam int TREG_A   = 'h040;
    localparam int MIR_LO_A = 'hF00;
    localparam int MIR_HI_A = 'hFFF;

    localparam logic [31:0] MC_STAT_VAL   = 32'd5;
    localparam logic [31:0] FIFO_FREE_VAL = 32'd64;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PTR,
        RG_WIN,
        RG_CONST,
        RG_TREG
    } region_e;

    function automatic logic [2:0] size_bytes(size_e sz);
        case (sz)
            SZ_B:    return 3'd1;
            SZ_H:    return 3'd2;
            SZ_W:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] width_mask(size_e sz);
        case (sz)
            SZ_B:    return 32'h0000_00FF;
            SZ_H:    return 32'h0000_FFFF;
            SZ_W:    return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(size_e sz);
        case (sz)
            SZ_B:    return 4'b0001;
            SZ_H:    return 4'b0011;
            SZ_W:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] lane_extract(logic [31:0] w, logic [1:0] off, size_e sz);
        logic [31:0] s;
        s = w >> {off, 3'b000};
        return s & width_mask(sz);
    endfunction

    function automatic logic [31:0] lane_deposit(logic [31:0] w, logic [1:0] off, size_e sz,
                                                 logic [31:0] wd);
        logic [31:0] r;
        int          o;
        int          n;
        r = w;
        o = int'(off);
        n = int'(size_bytes(sz));
        for (int b = 0; b < 4; b++) begin
            if (b >= o && (b - o) < n) begin
                r[b*8 +: 8] = wd[(b - o)*8 +: 8];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/idxwin_dec.sv
module idxwin_dec
    import idxwin_pkg::*;
#(
    parameter int          ADDR_W    = 14,
    parameter int          TREG_N    = 4,
    parameter int          SEL_W     = 2,
    parameter int          MEM_BYTES = 1024,
    parameter logic [31:0] MIRROR_ID = 32'h1AB0_0C3D
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [SEL_W-1:0]  treg_sel,
    output logic [31:0]       const_word
);
    int wa;

    always_comb begin
        wa         = int'(addr[ADDR_W-1:2]);
        region     = RG_NONE;
        treg_sel   = '0;
        const_word = '0;
        if (wa == (PTR_A >> 2)) begin
            region = RG_PTR;
        end else if (wa == (WIN_A >> 2)) begin
            region = RG_WIN;
        end else if (wa == (MSZ_A >> 2)) begin
            region     = RG_CONST;
            const_word = 32'(MEM_BYTES);
        end else if (wa == (MCS_A >> 2)) begin
            region     = RG_CONST;
            const_word = MC_STAT_VAL;
        end else if (wa == (ENG_A >> 2) || wa == (GUI_A >> 2)) begin
            region     = RG_CONST;
            const_word = FIFO_FREE_VAL;
        end else if (wa >= (TREG_A >> 2) && wa < (TREG_A >> 2) + TREG_N) begin
            region   = RG_TREG;
            treg_sel = SEL_W'(wa - (TREG_A >> 2));
        end else if (wa >= (MIR_LO_A >> 2) && wa <= (MIR_HI_A >> 2)) begin
            region     = RG_CONST;
            const_word = (wa == (MIR_LO_A >> 2)) ? MIRROR_ID : 32'h0;
        end
    end
endmodule

// File: rtl/idxwin_regbank.sv
module idxwin_regbank #(
    parameter int TREG_N = 4,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [31:0]      wr_word,
    output logic [31:0]      rd_word
);
    logic [31:0] regs [TREG_N];

    for (genvar g = 0; g < TREG_N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && int'(sel) == g) begin
                regs[g] <= wr_word;
            end
        end
    end

    assign rd_word = (int'(sel) < TREG_N) ? regs[sel] : 32'h0;
endmodule

// File: rtl/idxwin_mem.sv
module idxwin_mem #(
    parameter int MEM_BYTES = 1024,
    parameter int MEM_AW    = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] base,
    input  logic [3:0]        lane_en,
    input  logic [31:0]       wbytes,
    output logic [31:0]       rbytes
);
    logic [7:0]        mem [MEM_BYTES];
    logic [MEM_AW-1:0] lane_a [4];

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign lane_a[i]       = base + MEM_AW'(i);
        assign rbytes[i*8 +: 8] = mem[lane_a[i]];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (wr_en && lane_en[i]) begin
                mem[lane_a[i]] <= wbytes[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
    import idxwin_pkg::*;
#(
    parameter int          ADDR_W    = 14,
    parameter int          MEM_BYTES = 1024,
    parameter int          TREG_N    = 4,
    parameter logic [31:0] MIRROR_ID = 32'h1AB0_0C3D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic              ack,
    output logic [31:0]       rdata
);
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam int SEL_W  = (TREG_N > 1) ? $clog2(TREG_N) : 1;

    logic [31:0] idx_q;
    size_e       sz;
    logic        sz_ok, in_win, mem_sel, fwd_far, in_bounds, mem_go;
    logic [1:0]  off;
    logic [31:0] tgt, maddr, cur_word, new_word, rd_next, mem_rd, treg_rd, const_word;
    logic [ADDR_W-1:0] eff_addr;
    region_e     region_raw, region;
    logic [SEL_W-1:0] treg_sel;

    assign sz       = size_e'(size);
    assign sz_ok    = (sz != SZ_BAD);
    assign off      = addr[1:0];
    assign in_win   = (int'(addr[ADDR_W-1:2]) == (WIN_A >> 2));
    assign mem_sel  = in_win && idx_q[31];
    assign tgt      = idx_q + {30'h0, off};
    assign fwd_far  = (tgt >> ADDR_W) != 32'h0;
    assign eff_addr = in_win ? tgt[ADDR_W-1:0] : addr;

    // Memory path: bounds check against the configured size
    assign maddr     = {1'b0, idx_q[30:0]} + {30'h0, off};
    assign in_bounds = (maddr + {29'h0, size_bytes(sz)}) <= 32'(MEM_BYTES);
    assign mem_go    = req && sz_ok && mem_sel && in_bounds;

    idxwin_dec #(
        .ADDR_W(ADDR_W), .TREG_N(TREG_N), .SEL_W(SEL_W),
        .MEM_BYTES(MEM_BYTES), .MIRROR_ID(MIRROR_ID)
    ) dec_i (
        .addr(eff_addr), .region(region_raw), .treg_sel(treg_sel), .const_word(const_word)
    );

    // A forwarded target beyond the register space is unmapped; one that lands
    // on the window decodes as RG_WIN and falls into the default arm below.
    assign region = (in_win && !idx_q[31] && fwd_far) ? RG_NONE : region_raw;

    always_comb begin
        case (region)
            RG_PTR:   cur_word = idx_q;
            RG_CONST: cur_word = const_word;
            RG_TREG:  cur_word = treg_rd;
            default:  cur_word = 32'h0;
        endcase
    end

    assign new_word = lane_deposit(cur_word, eff_addr[1:0], sz, wdata);

    idxwin_regbank #(.TREG_N(TREG_N), .SEL_W(SEL_W)) bank_i (
        .clk(clk), .rst(rst),
        .wr_en(req && we && sz_ok && !mem_sel && region == RG_TREG),
        .sel(treg_sel), .wr_word(new_word), .rd_word(treg_rd)
    );

    idxwin_mem #(.MEM_BYTES(MEM_BYTES), .MEM_AW(MEM_AW)) mem_i (
        .clk(clk), .wr_en(mem_go && we), .base(maddr[MEM_AW-1:0]),
        .lane_en(lane_mask(sz)), .wbytes(wdata), .rbytes(mem_rd)
    );

    always_comb begin
        rd_next = 32'h0;
        if (req && !we && sz_ok) begin
            if (mem_sel) begin
                rd_next = mem_go ? (mem_rd & width_mask(sz)) : 32'h0;
            end else begin
                rd_next = lane_extract(cur_word, eff_addr[1:0], sz);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= req;
            rdata <= rd_next;
            if (req && we && sz_ok && !mem_sel && region == RG_PTR) begin
                idx_q <= new_word;
            end
        end
    end
endmodule

// File: rtl/idxwin_chk.sv
module idxwin_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic [31:0]       wdata,
    input logic              ack,
    input logic [31:0]       rdata,
    input logic [31:0]       idx_q
);
    // R1
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst) req |=> ack);
    // R1
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst) !req |=> !ack);
    // R1
    wr_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst) (req && we) |=> rdata == 32'h0);
    // R3
    bad_size_chk: assert property (@(posedge clk) disable iff (rst) (req && size == 2'd3) |=> rdata == 32'h0);
    // R4
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !we && size == 2'd0) |=> rdata[31:8] == 24'h0);
    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req && we && size == 2'd2 && addr == '0) |=> idx_q == $past(wdata));
    // R9
    mc_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !we && size == 2'd2 && addr == ADDR_W'(32'h14)) |=> rdata == 32'd5);
endmodule

bind idxwin_top idxwin_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .ack(ack), .rdata(rdata), .idx_q(idx_q)
);

// File: tb/idxwin_top_tb_top.sv
module idxwin_top_tb_top;
    localparam int          ADDR_W    = 14;
    localparam int          MEM_BYTES = 1024;
    localparam logic [31:0] MIR_ID    = 32'h1AB0_0C3D;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              we  = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        size = '0;
    logic [31:0]       wdata = '0;
    logic              ack;
    logic [31:0]       rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    idxwin_top #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .TREG_N(4), .MIRROR_ID(MIR_ID)) dut_i (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .ack(ack), .rdata(rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input int a, input logic [1:0] sz, input logic [31:0] wd,
                       output logic [31:0] rd);
        @(negedge clk);
        req = 1'b1; we = w; addr = ADDR_W'(a); size = sz; wdata = wd;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd = rdata;
        check(ack == 1'b1, "R1 ack", {31'h0, ack}, 32'h1);
    endtask

    task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] d;
        acc(1'b1, a, sz, wd, d);
        check(d == 32'h0, "R1 write rdata", d, 32'h0);
    endtask

    task automatic rd_exp(input int a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        acc(1'b0, a, sz, 32'h0, d);
        check(d == exp, tag, d, exp);
    endtask

    task automatic t_reset;
        check(ack == 1'b0, "R13 ack", {31'h0, ack}, 32'h0);
        check(rdata == 32'h0, "R13 rdata", rdata, 32'h0);
        rd_exp('h000, 2'd2, 32'h0, "R13 ptr");
        @(negedge clk);
        check(ack == 1'b0, "R1 idle ack", {31'h0, ack}, 32'h0);
    endtask

    task automatic t_pointer;
        wr('h000, 2'd2, 32'h1234_5678);
        rd_exp('h000, 2'd2, 32'h1234_5678, "R2 ptr word");
        rd_exp('h002, 2'd0, 32'h0000_0034, "R4 byte at off2");
        rd_exp('h001, 2'd1, 32'h0000_3456, "R4 half at off1");
        wr('h000, 2'd2, 32'h0);
    endtask

    task automatic t_bank;
        wr('h040, 2'd2, 32'hAABB_CCDD);
        wr('h041, 2'd0, 32'hFFFF_FF11);
        rd_exp('h040, 2'd2, 32'hAABB_11DD, "R4 byte deposit");
        wr('h043, 2'd1, 32'h0000_9988);
        rd_exp('h040, 2'd2, 32'h88BB_11DD, "R4 drop past bit31");
        rd_exp('h044, 2'd2, 32'h0, "R11 reset value");
        wr('h04C, 2'd2, 32'hCAFE_F00D);
        rd_exp('h04C, 2'd2, 32'hCAFE_F00D, "R11 last reg");
    endtask

    task automatic t_status;
        rd_exp('h010, 2'd2, 32'(MEM_BYTES), "R9 mem size");
        rd_exp('h014, 2'd2, 32'd5, "R9 mc status");
        rd_exp('h018, 2'd2, 32'd64, "R9 engine status");
        rd_exp('h01C, 2'd2, 32'd64, "R9 gui status");
        wr('h014, 2'd2, 32'hFFFF_FFFF);
        rd_exp('h014, 2'd2, 32'd5, "R9 write ignored");
    endtask

    task automatic t_mirror;
        rd_exp('hF00, 2'd2, MIR_ID, "R10 mirror id");
        rd_exp('hF01, 2'd0, {24'h0, MIR_ID[15:8]}, "R10 mirror byte");
        rd_exp('hF04, 2'd2, 32'h0, "R10 mirror zero");
        wr('hF00, 2'd2, 32'h0);
        rd_exp('hF00, 2'd2, MIR_ID, "R10 write ignored");
        wr('h100, 2'd2, 32'h5555_5555);
        rd_exp('h100, 2'd2, 32'h0, "R12 unmapped");
    endtask

    task automatic t_badsize;
        wr('h040, 2'd3, 32'h0);
        rd_exp('h040, 2'd2, 32'h88BB_11DD, "R3 size3 no write");
        rd_exp('h040, 2'd3, 32'h0, "R3 size3 read zero");
    endtask

    task automatic t_memory;
        wr('h000, 2'd2, 32'h8000_0010);
        wr('h004, 2'd2, 32'hDEAD_BEEF);
        rd_exp('h004, 2'd0, 32'h0000_00EF, "R5 lane0");
        rd_exp('h005, 2'd0, 32'h0000_00BE, "R5 offset added");
        rd_exp('h006, 2'd1, 32'h0000_DEAD, "R5 little endian half");
        rd_exp('h004, 2'd2, 32'hDEAD_BEEF, "R5 word");
        rd_exp('h040, 2'd2, 32'h88BB_11DD, "R5 bank untouched");
    endtask

    task automatic t_bounds;
        wr('h000, 2'd2, 32'h8000_03FC);
        wr('h004, 2'd2, 32'h0102_0304);
        rd_exp('h004, 2'd2, 32'h0102_0304, "R6 last word in range");
        wr('h000, 2'd2, 32'h8000_03FE);
        wr('h004, 2'd2, 32'hFFFF_FFFF);
        rd_exp('h004, 2'd1, 32'h0000_0102, "R6 overrun write dropped");
        rd_exp('h004, 2'd2, 32'h0, "R6 overrun read zero");
        wr('h000, 2'd2, 32'h8000_03FD);
        rd_exp('h007, 2'd0, 32'h0, "R6 byte past end");
        rd_exp('h006, 2'd0, 32'h0000_0001, "R6 last byte");
    endtask

    task automatic t_forward;
        wr('h000, 2'd2, 32'h0000_0040);
        wr('h004, 2'd2, 32'h5566_7788);
        rd_exp('h040, 2'd2, 32'h5566_7788, "R7 forwarded write");
        rd_exp('h006, 2'd0, 32'h0000_0066, "R7 forwarded byte offset");
        wr('h000, 2'd2, 32'h0000_0014);
        rd_exp('h004, 2'd2, 32'd5, "R7 forwarded status");
        wr('h000, 2'd2, 32'h0000_0004);
        rd_exp('h004, 2'd2, 32'h0, "R8 window target read");
        wr('h004, 2'd2, 32'h0000_0040);
        rd_exp('h000, 2'd2, 32'h0000_0004, "R8 window target write");
        wr('h000, 2'd2, 32'h0000_4040);
        rd_exp('h004, 2'd2, 32'h0, "R8 target above space");
        wr('h000, 2'd2, 32'h0);
        wr('h004, 2'd2, 32'h0000_0048);
        rd_exp('h000, 2'd2, 32'h0000_0048, "R7 forwarded pointer write");
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pointer();
        t_bank();
        t_status();
        t_mirror();
        t_badsize();
        t_memory();
        t_bounds();
        t_forward();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule